// File: doc/BRIEF.md
# Memory Barrier Ordering Unit

This block sits between an in-order issue stage and a single memory port. It watches the instruction stream for the synchronize barrier and enforces memory ordering on the load/store traffic that follows. Stores are held in a small in-order store queue. A load may overtake queued stores when its address matches none of them.

One opcode carries two barrier strengths, and a single class bit chooses between them. The heavy form holds the instruction handshake until every older access has left the unit: the store queue must be empty and no memory request may be outstanding. During that wait the unit raises a busy flag and counts the stall cycles. The lightweight form never stalls. It only places a fence marker on the youngest queued store, so that stores issued before the barrier are never merged with stores issued after it. Loads still bypass queued stores as before.

Every other instruction word passes straight through. The barrier writes no register state; its only effect is on the order in which accesses reach memory.

Top module: `mem_barrier_unit`

## Requirements
- R1: A word is a barrier only when bits [31:26] equal 31 and bits [10:1] equal 598; bit 0 is ignored. Every other word (for example 0x7c0006ac, 0x4c00012c, 0x38600001, 0x780004ac) is accepted at once (`insn_ready` high), never raises `barrier_busy` and never changes `stall_cycles`.
- R2: A barrier with bit 22 clear (heavy, e.g. 0x7c0004ac) keeps `insn_ready` low and `barrier_busy` high while the store queue holds any entry or a memory request is outstanding. It is accepted in the first cycle in which both are clear, so every older load and store has been acknowledged before it completes.
- R3: While `barrier_busy` is high, `acc_ready` is low, so no newer load or store enters the unit.
- R4: `stall_cycles` resets to 0, rises by one at each clock edge where `barrier_busy` is high, holds otherwise, and saturates at 0xFFFF.
- R5: A barrier with bit 22 set (lightweight, e.g. 0x7c4004ac) is accepted in the cycle it is presented, even with stores pending. A later load may still reach memory ahead of stores queued before the barrier.
- R6: Stores are queued in a FIFO of `SQ_DEPTH` entries (4 by default) and are written to memory in issue order, one per acknowledge. When the queue is full and the store cannot merge, `acc_ready` is low for stores.
- R7: When no request is outstanding, a load whose address matches no queued store is sent to memory before any queued store.
- R8: A load whose address equals that of a queued store keeps `acc_ready` low until that store has been sent to memory and acknowledged, then follows it.
- R9: A store whose address equals that of the youngest queued entry overwrites that entry's data instead of taking a new slot. This does not happen if a lightweight barrier was accepted after the youngest entry was queued, or if that entry is being sent to memory in the same cycle.
- R10: `mem_req` is a registered request; `mem_addr`, `mem_we` and `mem_wdata` hold stable until the cycle `mem_ack` is sampled high, and the next request is raised no earlier than the following cycle. A load acknowledge produces a one-cycle `load_done` in the next cycle, with `load_data` holding the `mem_rdata` sampled with the acknowledge.
- R11: Synchronous active-high reset empties the store queue, drops any request, clears `load_done` and `stall_cycles`, and leaves `insn_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Instruction word offered |
| insn_word | input | 32 | Instruction word |
| insn_ready | output | 1 | Instruction accepted this cycle when valid |
| acc_valid | input | 1 | Load/store access offered |
| acc_store | input | 1 | 1 = store, 0 = load |
| acc_addr | input | ADDR_W | Access address |
| acc_wdata | input | DATA_W | Store data |
| acc_ready | output | 1 | Access accepted this cycle when valid |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, completes the current request |
| mem_rdata | input | DATA_W | Read data, valid with the acknowledge of a load |
| load_done | output | 1 | One-cycle pulse: load data returned |
| load_data | output | DATA_W | Returned load data |
| barrier_busy | output | 1 | A heavy barrier is waiting for the drain |
| stall_cycles | output | STALL_W | Saturating count of heavy-barrier wait cycles |

## Verification
A behavioural model, built on queues, is compared with the ports on every cycle. It is driven first by directed sequences and then by a long mixed run. The directed sequences separate the cases one at a time. Held acknowledges with a heavy barrier show whether older stores drain before the barrier and whether a following load is held back. A lightweight barrier placed between same-address stores shows whether merging stops at the marker while loads still overtake. Loads to free and to queued addresses show bypass against forwarding-free waiting. A run of six stores shows the full-queue back-pressure. A barrier held for more than 65,535 cycles shows the saturation. The mixed run uses four addresses, random acknowledge gaps and every barrier word, so merging, hits and barrier waits all meet the same cycles.

// File: rtl/mbu_pkg.sv
package mbu_pkg;
  localparam int unsigned INSN_W      = 32;
  localparam logic [5:0]  SYNC_MAJOR  = 6'd31;
  localparam logic [9:0]  SYNC_MINOR  = 10'd598;
  localparam int unsigned CLASS_BIT   = 22;

  typedef enum logic [1:0] {
    ORD_NONE  = 2'd0,
    ORD_HEAVY = 2'd1,
    ORD_LIGHT = 2'd2
  } ord_kind_e;
endpackage

// File: rtl/mbu_decode.sv
module mbu_decode
  import mbu_pkg::*;
(
  input  logic [INSN_W-1:0] word,
  output ord_kind_e         kind
);
  logic is_sync;

  always_comb begin
    is_sync = (word[31:26] == SYNC_MAJOR) && (word[10:1] == SYNC_MINOR);
    if (!is_sync)             kind = ORD_NONE;
    else if (word[CLASS_BIT]) kind = ORD_LIGHT;
    else                      kind = ORD_HEAVY;
  end
endmodule

// File: rtl/mbu_store_queue.sv
module mbu_store_queue #(
  parameter  int DEPTH = 4,
  parameter  int AW    = 32,
  parameter  int DW    = 32,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             merge,
  input  logic             mark,
  input  logic             pop,
  input  logic [AW-1:0]    push_addr,
  input  logic [DW-1:0]    push_data,
  input  logic [AW-1:0]    probe_addr,
  output logic             probe_hit,
  output logic             tail_mergeable,
  output logic [AW-1:0]    head_addr,
  output logic [DW-1:0]    head_data,
  output logic [CNT_W-1:0] count
);
  logic [AW-1:0]    addr_mem [DEPTH];
  logic [DW-1:0]    data_mem [DEPTH];
  logic [DEPTH-1:0] fence_q;
  logic [PTR_W-1:0] head_q, tail_q, young_idx;
  logic [CNT_W-1:0] count_q;
  logic [DEPTH-1:0] live, hit_vec;
  logic             alloc;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign alloc     = push && !merge;
  assign young_idx = (tail_q == '0) ? PTR_W'(DEPTH - 1) : tail_q - 1'b1;
  assign head_addr = addr_mem[head_q];
  assign head_data = data_mem[head_q];
  assign count     = count_q;

  // one comparator per slot, qualified by the slot's age
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_comb begin
      live[i]    = ((i + DEPTH - int'(head_q)) % DEPTH) < int'(count_q);
      hit_vec[i] = live[i] && (addr_mem[i] == probe_addr);
    end
  end

  assign probe_hit      = |hit_vec;
  assign tail_mergeable = (count_q != '0) && (addr_mem[young_idx] == push_addr)
                          && !fence_q[young_idx];

  always_ff @(posedge clk) begin
    if (alloc) addr_mem[tail_q] <= push_addr;
    if (alloc) data_mem[tail_q] <= push_data;
    else if (merge) data_mem[young_idx] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
      fence_q <= '0;
    end else begin
      if (mark) fence_q[young_idx] <= 1'b1;
      if (alloc) begin
        fence_q[tail_q] <= 1'b0;
        tail_q          <= step(tail_q);
      end
      if (pop) head_q <= step(head_q);
      count_q <= count_q + CNT_W'(alloc) - CNT_W'(pop);
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    alloc |-> (int'(count_q) < DEPTH));
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count_q != '0));
  assert_merge_keeps_count_R9: assert property (@(posedge clk) disable iff (rst)
    (merge && !pop) |=> (count_q == $past(count_q)));
endmodule

// File: rtl/mbu_mem_port.sv
module mbu_mem_port #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue_ld,
  input  logic          issue_st,
  input  logic [AW-1:0] ld_addr,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          idle,
  output logic          ld_done,
  output logic [DW-1:0] ld_data
);
  logic done_now;

  assign idle     = !mem_req;
  assign done_now = mem_req && mem_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      ld_done   <= 1'b0;
      ld_data   <= '0;
    end else begin
      ld_done <= done_now && !mem_we;
      if (done_now && !mem_we) ld_data <= mem_rdata;
      if (done_now) mem_req <= 1'b0;
      if (issue_ld) begin
        mem_req   <= 1'b1;
        mem_we    <= 1'b0;
        mem_addr  <= ld_addr;
        mem_wdata <= '0;
      end else if (issue_st) begin
        mem_req   <= 1'b1;
        mem_we    <= 1'b1;
        mem_addr  <= st_addr;
        mem_wdata <= st_data;
      end
    end
  end

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));
  assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (rst)
    (issue_ld || issue_st) |-> !mem_req);
  assert_load_return_R10: assert property (@(posedge clk) disable iff (rst)
    ld_done |-> $past(mem_req && mem_ack && !mem_we));
endmodule

// File: rtl/mbu_stall_count.sv
module mbu_stall_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         stall,
  output logic [W-1:0] cycles
);
  always_ff @(posedge clk) begin
    if (rst)                         cycles <= '0;
    else if (stall && (cycles != '1)) cycles <= cycles + 1'b1;
  end

  assert_stall_saturate_R4: assert property (@(posedge clk) disable iff (rst)
    (cycles == '1) |=> (cycles == '1));
  assert_stall_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !stall |=> $stable(cycles));
endmodule

// File: rtl/mem_barrier_unit.sv
module mem_barrier_unit
  import mbu_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int SQ_DEPTH = 4,
  parameter int STALL_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               insn_valid,
  input  logic [INSN_W-1:0]  insn_word,
  output logic               insn_ready,
  input  logic               acc_valid,
  input  logic               acc_store,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic [DATA_W-1:0]  acc_wdata,
  output logic               acc_ready,
  output logic               mem_req,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic               mem_ack,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               load_done,
  output logic [DATA_W-1:0]  load_data,
  output logic               barrier_busy,
  output logic [STALL_W-1:0] stall_cycles
);
  localparam int CNT_W = $clog2(SQ_DEPTH + 1);

  ord_kind_e           kind;
  logic                port_idle, drained, light_fire;
  logic                hit, tail_ok, merge_ok;
  logic                ld_ok, st_ok, ld_fire, st_fire, sq_pop;
  logic [CNT_W-1:0]    sq_count;
  logic [ADDR_W-1:0]   head_addr;
  logic [DATA_W-1:0]   head_data;

  mbu_decode u_decode (
    .word (insn_word),
    .kind (kind)
  );

  always_comb begin
    drained      = (sq_count == '0) && port_idle;
    barrier_busy = insn_valid && (kind == ORD_HEAVY) && !drained;
    insn_ready   = !barrier_busy;
    light_fire   = insn_valid && (kind == ORD_LIGHT);
    // a load may leave only onto an idle port and past non-matching stores
    ld_ok        = !barrier_busy && port_idle && !hit;
    // never merge into an entry leaving this cycle or behind a fresh marker
    merge_ok     = tail_ok && !light_fire && !(port_idle && (sq_count == CNT_W'(1)));
    st_ok        = !barrier_busy && ((int'(sq_count) < SQ_DEPTH) || merge_ok);
    acc_ready    = acc_store ? st_ok : ld_ok;
    ld_fire      = acc_valid && !acc_store && ld_ok;
    st_fire      = acc_valid && acc_store && st_ok;
    sq_pop       = port_idle && (sq_count != '0) && !ld_fire;
  end

  mbu_store_queue #(
    .DEPTH (SQ_DEPTH),
    .AW    (ADDR_W),
    .DW    (DATA_W)
  ) u_sq (
    .clk            (clk),
    .rst            (rst),
    .push           (st_fire),
    .merge          (st_fire && merge_ok),
    .mark           (light_fire && (sq_count != '0)),
    .pop            (sq_pop),
    .push_addr      (acc_addr),
    .push_data      (acc_wdata),
    .probe_addr     (acc_addr),
    .probe_hit      (hit),
    .tail_mergeable (tail_ok),
    .head_addr      (head_addr),
    .head_data      (head_data),
    .count          (sq_count)
  );

  mbu_mem_port #(
    .AW (ADDR_W),
    .DW (DATA_W)
  ) u_port (
    .clk       (clk),
    .rst       (rst),
    .issue_ld  (ld_fire),
    .issue_st  (sq_pop),
    .ld_addr   (acc_addr),
    .st_addr   (head_addr),
    .st_data   (head_data),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .idle      (port_idle),
    .ld_done   (load_done),
    .ld_data   (load_data)
  );

  mbu_stall_count #(
    .W (STALL_W)
  ) u_stall (
    .clk    (clk),
    .rst    (rst),
    .stall  (barrier_busy),
    .cycles (stall_cycles)
  );

  assert_heavy_after_drain_R2: assert property (@(posedge clk) disable iff (rst)
    (insn_valid && insn_ready && (kind == ORD_HEAVY)) |-> ((sq_count == '0) && !mem_req));
  assert_busy_blocks_entry_R3: assert property (@(posedge clk) disable iff (rst)
    barrier_busy |=> (sq_count <= $past(sq_count)));
  assert_busy_no_load_R3: assert property (@(posedge clk) disable iff (rst)
    (barrier_busy && !mem_req) |=> !(mem_req && !mem_we));
  assert_light_no_stall_R5: assert property (@(posedge clk) disable iff (rst)
    light_fire |-> insn_ready);
endmodule

// File: tb/mem_barrier_unit_test.sv
module mem_barrier_unit_test;
  timeunit 1ns;
  timeprecision 100ps;

  localparam logic [31:0] W_HEAVY = 32'h7c0004ac;
  localparam logic [31:0] W_HVRC  = 32'h7c0004ad;
  localparam logic [31:0] W_LIGHT = 32'h7c4004ac;
  localparam logic [31:0] W_IOB   = 32'h7c0006ac;
  localparam logic [31:0] W_IFB   = 32'h4c00012c;
  localparam logic [31:0] W_ADD   = 32'h38600001;
  localparam logic [31:0] W_NEAR  = 32'h780004ac;

  logic        clk = 0;
  logic        rst = 1;
  logic        insn_valid = 0, insn_ready;
  logic [31:0] insn_word = 0;
  logic        acc_valid = 0, acc_store = 0, acc_ready;
  logic [31:0] acc_addr = 0, acc_wdata = 0;
  logic        mem_req, mem_we, mem_ack = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic        load_done, barrier_busy;
  logic [31:0] load_data;
  logic [15:0] stall_cycles;

  always #2.5 clk = ~clk;

  mem_barrier_unit uut (
    .clk(clk), .rst(rst),
    .insn_valid(insn_valid), .insn_word(insn_word), .insn_ready(insn_ready),
    .acc_valid(acc_valid), .acc_store(acc_store), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_ready(acc_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .load_done(load_done), .load_data(load_data),
    .barrier_busy(barrier_busy), .stall_cycles(stall_cycles)
  );

  typedef struct { logic st; logic [31:0] a; logic [31:0] d; } acc_t;
  typedef struct { logic [31:0] a; logic [31:0] d; bit f; } ent_t;
  typedef struct { int k; logic [31:0] a; logic [31:0] d; } ev_t;

  logic [31:0] ins_q[$];
  acc_t        acc_q[$];
  ent_t        mq[$];
  ev_t         evlog[$];

  int n_checks = 0, n_fail = 0, cyc = 0, wait_cnt = 0, ack_lat = 0;
  bit ack_hold = 0, rand_mode = 0, ins_taken = 0, acc_taken = 0;

  // model state
  bit          m_req, m_we, m_ldd;
  logic [31:0] m_addr, m_wd, m_ldata;
  int          m_stall;
  bit          m_busy, m_ins_ready, m_acc_ready, m_ld_ok, m_st_ok, m_merge;

  function automatic logic [31:0] rd_val(input logic [31:0] a);
    return a ^ 32'h5a5a0f0f;
  endfunction
  function automatic bit is_sync(input logic [31:0] w);
    return (w[31:26] == 6'd31) && (w[10:1] == 10'd598);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic model_comb();
    bit idle, light, heavy;
    idle  = !m_req;
    heavy = insn_valid && is_sync(insn_word) && !insn_word[22];
    light = insn_valid && is_sync(insn_word) && insn_word[22];
    m_busy = heavy && !(mq.size() == 0 && idle);
    m_ins_ready = !m_busy;
    m_ld_ok = !m_busy && idle;
    foreach (mq[i]) if (mq[i].a == acc_addr) m_ld_ok = 0;
    m_merge = (mq.size() > 0) && !light && !(idle && mq.size() == 1);
    if (m_merge) m_merge = (mq[mq.size()-1].a == acc_addr) && !mq[mq.size()-1].f;
    m_st_ok = !m_busy && (mq.size() < 4 || m_merge);
    m_acc_ready = acc_store ? m_st_ok : m_ld_ok;
  endtask

  task automatic model_step();
    bit idle, ldf, stf, pop, light;
    if (rst) begin
      mq.delete(); m_req = 0; m_we = 0; m_addr = 0; m_wd = 0; m_ldd = 0; m_ldata = 0;
      m_stall = 0; ins_taken = 0; acc_taken = 0; wait_cnt = 0;
      return;
    end
    if (mem_req && mem_ack) evlog.push_back('{k: mem_we ? 1 : 0, a: mem_addr, d: mem_wdata});
    if (insn_valid && insn_ready && is_sync(insn_word))
      evlog.push_back('{k: insn_word[22] ? 3 : 2, a: 0, d: 0});
    idle  = !m_req;
    light = insn_valid && is_sync(insn_word) && insn_word[22];
    ldf = acc_valid && !acc_store && m_ld_ok;
    stf = acc_valid && acc_store && m_st_ok;
    pop = idle && mq.size() > 0 && !ldf;
    ins_taken = insn_valid && m_ins_ready;
    acc_taken = acc_valid && m_acc_ready;
    if (m_busy && m_stall < 65535) m_stall++;
    m_ldd = m_req && mem_ack && !m_we;
    if (m_ldd) m_ldata = mem_rdata;
    if (m_req && mem_ack) m_req = 0;
    if (ldf) begin m_req = 1; m_we = 0; m_addr = acc_addr; m_wd = 0; end
    else if (pop) begin m_req = 1; m_we = 1; m_addr = mq[0].a; m_wd = mq[0].d; end
    if (light && mq.size() > 0) mq[mq.size()-1].f = 1;
    if (stf && m_merge) mq[mq.size()-1].d = acc_wdata;
    if (pop) void'(mq.pop_front());
    if (stf && !m_merge) mq.push_back('{a: acc_addr, d: acc_wdata, f: 0});
    if (mem_req && !mem_ack) wait_cnt++; else wait_cnt = 0;
  endtask

  task automatic compare_regs();
    check(mem_req == m_req, "R10", "mem_req", 32'(mem_req), 32'(m_req));
    if (m_req) begin
      check(mem_we == m_we, "R7", "mem_we", 32'(mem_we), 32'(m_we));
      check(mem_addr == m_addr, "R6", "mem_addr", mem_addr, m_addr);
      if (m_we) check(mem_wdata == m_wd, "R9", "mem_wdata", mem_wdata, m_wd);
    end
    check(load_done == m_ldd, "R10", "load_done", 32'(load_done), 32'(m_ldd));
    if (m_ldd) check(load_data == rd_val(m_addr_prev), "R10", "load_data", load_data,
                     rd_val(m_addr_prev));
    check(int'(stall_cycles) == m_stall, "R4", "stall_cycles", 32'(stall_cycles), 32'(m_stall));
  endtask

  logic [31:0] m_addr_prev = 0;

  task automatic compare_comb();
    check(barrier_busy == m_busy, "R2", "barrier_busy", 32'(barrier_busy), 32'(m_busy));
    check(insn_ready == m_ins_ready, "R1", "insn_ready", 32'(insn_ready), 32'(m_ins_ready));
    check(acc_ready == m_acc_ready, acc_store ? "R6" : "R8", "acc_ready",
          32'(acc_ready), 32'(m_acc_ready));
  endtask

  // driver, reference model and per-cycle comparison
  always begin
    bit gap;
    @(negedge clk);
    cyc++;
    rst = (cyc <= 4);
    if (!rst) compare_regs();
    if (rst) begin
      insn_valid = 0; acc_valid = 0; mem_ack = 0;
    end else begin
      gap = rand_mode && ($urandom % 4 == 0);
      if (!(insn_valid && !ins_taken)) begin
        if (ins_q.size() > 0 && !gap) begin insn_valid = 1; insn_word = ins_q.pop_front(); end
        else insn_valid = 0;
      end
      if (!(acc_valid && !acc_taken)) begin
        if (acc_q.size() > 0 && !gap) begin
          acc_t x;
          x = acc_q.pop_front();
          acc_valid = 1; acc_store = x.st; acc_addr = x.a; acc_wdata = x.d;
        end else acc_valid = 0;
      end
      if (!mem_req || ack_hold) mem_ack = 0;
      else if (rand_mode) mem_ack = ($urandom % 3 != 0);
      else mem_ack = (wait_cnt >= ack_lat);
      mem_rdata = rd_val(mem_addr);
    end
    #1;
    model_comb();
    if (!rst) compare_comb();
    if (m_req && mem_ack && !m_we) m_addr_prev = m_addr;
    model_step();
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic st(input logic [31:0] a, input logic [31:0] d);
    acc_q.push_back('{st: 1, a: a, d: d});
  endtask
  task automatic ld(input logic [31:0] a);
    acc_q.push_back('{st: 0, a: a, d: 0});
  endtask
  task automatic expect_ev(input int idx, input int k, input logic [31:0] a,
                           input logic [31:0] d, input string req);
    if (idx >= evlog.size()) check(0, req, "event missing", 32'(evlog.size()), 32'(idx + 1));
    else begin
      check(evlog[idx].k == k, req, "event kind", 32'(evlog[idx].k), 32'(k));
      check(evlog[idx].a == a, req, "event addr", evlog[idx].a, a);
      if (k == 1) check(evlog[idx].d == d, req, "event data", evlog[idx].d, d);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    check(0, "R11", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int s0;
    wait (cyc == 6);
    @(negedge clk); #3;
    // R11: reset state
    check(!mem_req && !load_done && !barrier_busy, "R11", "idle after reset",
          {mem_req, load_done, barrier_busy}, 0);
    check(stall_cycles == 0 && insn_ready, "R11", "counter/ready after reset",
          {stall_cycles, 15'd0, insn_ready}, 1);

    // R1, R2, R3: heavy barrier behind pending stores
    evlog.delete(); ack_hold = 1; ack_lat = 1;
    st(32'h200, 1); st(32'h204, 2); st(32'h208, 3);
    cycles(8);
    s0 = stall_cycles;
    ins_q.push_back(W_IOB); ins_q.push_back(W_IFB); ins_q.push_back(W_ADD);
    ins_q.push_back(W_NEAR);
    cycles(8); #3;
    check(stall_cycles == s0, "R1", "non-barrier words stall", stall_cycles, s0);
    check(evlog.size() == 0, "R1", "non-barrier words logged as barriers", evlog.size(), 0);
    ins_q.push_back(W_HVRC);
    ld(32'h300);
    cycles(12); #3;
    check(barrier_busy && !insn_ready, "R2", "heavy barrier waits", {barrier_busy, insn_ready}, 2);
    check(!acc_ready && acc_valid, "R3", "load held during barrier", acc_ready, 0);
    check(stall_cycles > s0, "R4", "stall counted", stall_cycles, s0 + 1);
    ack_hold = 0;
    cycles(30);
    expect_ev(0, 1, 32'h200, 1, "R2"); expect_ev(1, 1, 32'h204, 2, "R2");
    expect_ev(2, 1, 32'h208, 3, "R2"); expect_ev(3, 2, 0, 0, "R2");
    expect_ev(4, 0, 32'h300, 0, "R3");

    // R7, R8: bypass and address-match wait
    evlog.delete(); ack_hold = 1; ack_lat = 2;
    st(32'h400, 10); st(32'h404, 11); st(32'h408, 12); ld(32'h40c); ld(32'h408);
    cycles(10);
    ack_hold = 0;
    cycles(40);
    expect_ev(0, 1, 32'h400, 10, "R7"); expect_ev(1, 0, 32'h40c, 0, "R7");
    expect_ev(2, 1, 32'h404, 11, "R8"); expect_ev(3, 1, 32'h408, 12, "R8");
    expect_ev(4, 0, 32'h408, 0, "R8");

    // R5, R9: lightweight marker stops merging, loads still bypass
    evlog.delete(); ack_hold = 1; ack_lat = 0;
    st(32'h500, 1); st(32'h500, 2); st(32'h500, 3);
    cycles(6);
    ins_q.push_back(W_LIGHT);
    cycles(3);
    st(32'h500, 4); ld(32'h504);
    cycles(6);
    ack_hold = 0;
    cycles(30);
    expect_ev(0, 3, 0, 0, "R5");
    expect_ev(1, 1, 32'h500, 1, "R9"); expect_ev(2, 0, 32'h504, 0, "R5");
    expect_ev(3, 1, 32'h500, 3, "R9"); expect_ev(4, 1, 32'h500, 4, "R9");
    check(evlog.size() == 5, "R9", "write count after merge", evlog.size(), 5);

    // R6: full queue back-pressure and in-order retirement
    evlog.delete(); ack_hold = 1; ack_lat = 1;
    for (int i = 0; i < 6; i++) st(32'h600 + 4 * i, 32'h60 + i);
    cycles(15); #3;
    check(acc_valid && acc_store && !acc_ready, "R6", "store accepted into full queue",
          acc_ready, 0);
    ack_hold = 0;
    cycles(40);
    for (int i = 0; i < 6; i++) expect_ev(i, 1, 32'h600 + 4 * i, 32'h60 + i, "R6");

    // R4: saturation under a very long heavy wait
    ack_hold = 1;
    st(32'h700, 7);
    cycles(4);
    ins_q.push_back(W_HEAVY);
    cycles(65600); #3;
    check(stall_cycles == 16'hffff, "R4", "saturated stall count", stall_cycles, 16'hffff);
    ack_hold = 0;
    cycles(10); #3;
    check(stall_cycles == 16'hffff && !barrier_busy, "R4", "saturation held after drain",
          stall_cycles, 16'hffff);

    // mixed traffic against the model
    rand_mode = 1;
    for (int i = 0; i < 700; i++) begin
      logic [31:0] a;
      a = 32'h800 + 4 * ($urandom % 4);
      case ($urandom % 8)
        0: ins_q.push_back(W_HEAVY);
        1: ins_q.push_back(W_LIGHT);
        2: ins_q.push_back(($urandom % 2) ? W_IOB : W_HVRC);
        3, 4: ld(a);
        default: st(a, $urandom);
      endcase
    end
    while (ins_q.size() > 0 || acc_q.size() > 0) cycles(1);
    rand_mode = 0;
    cycles(40); #3;
    check(!mem_req && !barrier_busy, "R6", "quiet after mixed traffic", {mem_req, barrier_busy}, 0);
    finish_run();
  end
endmodule